// File: doc/BRIEF.md
# Circular Return-Address Stack with Floating Program Counter

This block keeps the fetch address of a small processor core. It has no dedicated program-counter register. Eight 14-bit address slots form a ring, and a 3-bit pointer selects one of them. The selected slot is the live fetch address. A subroutine call moves the pointer forward by one slot and loads the new slot with the destination. The slot the pointer leaves keeps the address that execution returns to. A return moves the pointer back one slot, and fetching continues from the address stored there.

The instruction decoder drives the block with single-cycle strobes that have already been qualified by any flag condition. The strobes are: advance, jump, three-byte call, one-byte vectored call and return. A hold input suppresses address increments while an interrupting device supplies the fetched instruction. This keeps the instruction in memory from being skipped. A branch destination is built from two instruction bytes: a 6-bit upper part and an 8-bit lower part. Nesting beyond the ring depth wraps without notice and overwrites the oldest saved address.

Top module: `retstack_pc`

## Requirements
- R1: After reset the fetch address is 0x0000 and every slot holds zero. A return issued straight after reset therefore yields 0x0000.
- R2: An advance strobe without hold raises the fetch address by one on the next clock. 0x3FFF is followed by 0x0000.
- R3: A jump replaces the fetch address with {tgt_hi_i, tgt_lo_i}. tgt_hi_i forms bits 13:8 and tgt_lo_i forms bits 7:0. The pointer does not move.
- R4: A three-byte call stores the current address plus 3 in the current slot and moves the pointer up by one. The fetch address becomes {tgt_hi_i, tgt_lo_i}.
- R5: A return moves the pointer down by one. The fetch address becomes the value stored in that slot.
- R6: A one-byte call jumps to vec_i times 8: bits 5:3 are vec_i and all other bits are zero. It stores the current address plus 1 as the return address.
- R7: While hold_i is high, an advance strobe leaves the fetch address unchanged. A call of either kind then saves the current address with no increment added.
- R8: Eight nested calls wrap the pointer to its starting slot and overwrite that slot's saved address. The eighth return therefore yields the eighth call's destination.
- R9: When several strobes are high together, exactly one takes effect. The order of precedence is call, one-byte call, jump, return, advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Advance the fetch address by one |
| hold_i | input | 1 | Suppress increments (interrupt fetch) |
| jump_i | input | 1 | Qualified jump strobe |
| call_i | input | 1 | Qualified three-byte call strobe |
| vcall_i | input | 1 | Qualified one-byte vectored call strobe |
| ret_i | input | 1 | Qualified return strobe |
| tgt_hi_i | input | 6 | Upper destination bits, from the second instruction byte |
| tgt_lo_i | input | 8 | Lower destination bits, from the third instruction byte |
| vec_i | input | 3 | Vector number for the one-byte call |
| pc_o | output | 14 | Current fetch address (selected slot) |

## Verification
The hardest case to reach from the ports is the ring wrap. Slot overwrite only shows after eight calls in a row and eight returns, and only if every destination is distinct. Otherwise a stale address cannot be told apart from the one that overwrote it. The stimulus uses a different upper byte for each of the eight calls. It then unwinds all of them and expects the last return to land on the eighth destination, not on the original return address. Hold combined with a vectored call is also covered, to show that the saved address carries no increment.

// File: rtl/rspc_pkg.sv
package rspc_pkg;
  parameter int ADDR_W    = 14;
  parameter int HI_W      = 6;
  parameter int LO_W      = 8;
  parameter int VEC_W     = 3;
  parameter int VEC_SHIFT = 3;
  parameter int DEPTH     = 8;
  parameter int PTR_W     = $clog2(DEPTH);
  parameter int CALL_LEN  = 3;
  parameter int VCALL_LEN = 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PTR_W-1:0]  ptr_t;

  typedef enum logic [2:0] {
    OP_IDLE, OP_STEP, OP_JUMP, OP_CALL, OP_VCALL, OP_RET
  } op_e;

  function automatic addr_t f_join(input logic [HI_W-1:0] hi, input logic [LO_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic addr_t f_vector(input logic [VEC_W-1:0] v);
    addr_t a;
    a = '0;
    a[VEC_SHIFT +: VEC_W] = v;
    return a;
  endfunction

  function automatic addr_t f_advance(input addr_t a, input int unsigned n);
    return a + addr_t'(n);
  endfunction

  function automatic addr_t f_link(input addr_t a, input int unsigned len, input logic hold);
    return hold ? a : f_advance(a, len);
  endfunction
endpackage

// File: rtl/rspc_decode.sv
module rspc_decode
  import rspc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic hold_i,
  input  logic jump_i,
  input  logic call_i,
  input  logic vcall_i,
  input  logic ret_i,
  output op_e  op_o
);
  always_comb begin
    if (call_i)                op_o = OP_CALL;
    else if (vcall_i)          op_o = OP_VCALL;
    else if (jump_i)           op_o = OP_JUMP;
    else if (ret_i)            op_o = OP_RET;
    else if (step_i && !hold_i) op_o = OP_STEP;
    else                       op_o = OP_IDLE;
  end

  p_call_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |-> op_o == OP_CALL);
  p_vcall_over_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vcall_i && !call_i) |-> op_o == OP_VCALL);
  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !jump_i && !call_i && !vcall_i && !ret_i) |-> op_o == OP_IDLE);
endmodule

// File: rtl/rspc_pointer.sv
module rspc_pointer
  import rspc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  output ptr_t ptr_o,
  output ptr_t ptr_up_o
);
  ptr_t ptr_q;

  assign ptr_o    = ptr_q;
  assign ptr_up_o = ptr_q + ptr_t'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (push_i) ptr_q <= ptr_up_o;
    else if (pop_i)  ptr_q <= ptr_q - ptr_t'(1);
  end

  p_push_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> ptr_q == ptr_t'($past(ptr_q) + ptr_t'(1)));
  p_pop_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> ptr_q == ptr_t'($past(ptr_q) - ptr_t'(1)));
  p_idle_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_i && !push_i) |=> $stable(ptr_q));
endmodule

// File: rtl/rspc_file.sv
module rspc_file
  import rspc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ptr_t  cur_i,
  input  ptr_t  up_i,
  input  logic  cur_we_i,
  input  addr_t cur_d_i,
  input  logic  up_we_i,
  input  addr_t up_d_i,
  output addr_t rd_o
);
  addr_t slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    addr_t q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  q <= '0;
      else if (cur_we_i && cur_i == ptr_t'(i))     q <= cur_d_i;
      else if (up_we_i && up_i == ptr_t'(i))       q <= up_d_i;
    end
    assign slot[i] = q;
  end

  assign rd_o = slot[cur_i];

  p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_we_i && up_we_i) |-> cur_i != up_i);
endmodule

// File: rtl/retstack_pc.sv
module retstack_pc
  import rspc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              hold_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic              vcall_i,
  input  logic              ret_i,
  input  logic [HI_W-1:0]   tgt_hi_i,
  input  logic [LO_W-1:0]   tgt_lo_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] pc_o
);
  op_e   op;
  ptr_t  ptr, ptr_up;
  addr_t pc, tgt, vtgt, cur_d, up_d;
  logic  push, pop, cur_we, up_we;

  rspc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .hold_i(hold_i),
    .jump_i(jump_i), .call_i(call_i), .vcall_i(vcall_i), .ret_i(ret_i),
    .op_o(op)
  );

  assign push = (op == OP_CALL) || (op == OP_VCALL);
  assign pop  = (op == OP_RET);

  rspc_pointer u_ptr (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
    .ptr_o(ptr), .ptr_up_o(ptr_up)
  );

  assign tgt  = f_join(tgt_hi_i, tgt_lo_i);
  assign vtgt = f_vector(vec_i);

  always_comb begin
    cur_we = 1'b1;
    up_we  = push;
    cur_d  = pc;
    up_d   = tgt;
    unique case (op)
      OP_STEP:  cur_d = f_advance(pc, 1);
      OP_JUMP:  cur_d = tgt;
      OP_CALL:  cur_d = f_link(pc, CALL_LEN, hold_i);
      OP_VCALL: begin
        cur_d = f_link(pc, VCALL_LEN, hold_i);
        up_d  = vtgt;
      end
      default:  cur_we = 1'b0;
    endcase
  end

  rspc_file u_file (
    .clk(clk), .rst_n(rst_n), .cur_i(ptr), .up_i(ptr_up),
    .cur_we_i(cur_we), .cur_d_i(cur_d), .up_we_i(up_we), .up_d_i(up_d),
    .rd_o(pc)
  );

  assign pc_o = pc;

  p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> pc_o == $past(pc_o) + addr_t'(1));
  p_hold_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |=> $stable(pc_o));
  p_jump_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JUMP) |=> pc_o == $past(tgt));
  p_call_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CALL) |=> pc_o == $past(tgt));
  p_vec_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_VCALL) |=> (pc_o[VEC_SHIFT-1:0] == '0) &&
                         (pc_o[VEC_SHIFT +: VEC_W] == $past(vec_i)));
endmodule

// File: tb/retstack_pc_test.sv
module retstack_pc_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 0, hold_i = 0, jump_i = 0, call_i = 0, vcall_i = 0, ret_i = 0;
  logic [5:0]  tgt_hi_i = '0;
  logic [7:0]  tgt_lo_i = '0;
  logic [2:0]  vec_i = '0;
  logic [13:0] pc_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  retstack_pc uut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .hold_i(hold_i),
    .jump_i(jump_i), .call_i(call_i), .vcall_i(vcall_i), .ret_i(ret_i),
    .tgt_hi_i(tgt_hi_i), .tgt_lo_i(tgt_lo_i), .vec_i(vec_i), .pc_o(pc_o)
  );

  task automatic check(input string req, input logic [13:0] exp);
    checks++;
    if (pc_o !== exp) begin
      fails++;
      $display("FAIL %s: pc actual 0x%04h expected 0x%04h", req, pc_o, exp);
    end
  endtask

  // Apply strobes for one clock; result is visible on return.
  task automatic pulse(input logic s, input logic h, input logic j, input logic c,
                       input logic v, input logic r, input logic [13:0] t,
                       input logic [2:0] vec);
    step_i = s; hold_i = h; jump_i = j; call_i = c; vcall_i = v; ret_i = r;
    tgt_hi_i = t[13:8]; tgt_lo_i = t[7:0]; vec_i = vec;
    @(negedge clk);
    step_i = 0; hold_i = 0; jump_i = 0; call_i = 0; vcall_i = 0; ret_i = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset address", 14'h0000);
    pulse(0,0,0,0,0,1, 14'h0, 3'd0);
    check("R1 slots cleared", 14'h0000);
  endtask

  task automatic t_step_jump();
    do_reset();
    repeat (5) pulse(1,0,0,0,0,0, 14'h0, 3'd0);
    check("R2 five advances", 14'h0005);
    pulse(0,0,1,0,0,0, 14'h3FFF, 3'd0);
    check("R3 jump high/low bytes", 14'h3FFF);
    pulse(1,0,0,0,0,0, 14'h0, 3'd0);
    check("R2 wrap to zero", 14'h0000);
    pulse(0,0,1,0,0,0, 14'h2A5C, 3'd0);
    check("R3 jump pattern", 14'h2A5C);
  endtask

  task automatic t_call_ret();
    do_reset();
    pulse(0,0,1,0,0,0, 14'h0100, 3'd0);
    pulse(0,0,0,1,0,0, 14'h0234, 3'd0);
    check("R4 call destination", 14'h0234);
    pulse(1,0,0,0,0,0, 14'h0, 3'd0);
    pulse(0,0,0,1,0,0, 14'h3FF0, 3'd0);
    check("R4 nested call", 14'h3FF0);
    pulse(0,0,0,0,0,1, 14'h0, 3'd0);
    check("R5 inner return", 14'h0238);
    pulse(0,0,0,0,0,1, 14'h0, 3'd0);
    check("R5 outer return", 14'h0103);
  endtask

  task automatic t_vector();
    do_reset();
    pulse(0,0,1,0,0,0, 14'h0050, 3'd0);
    pulse(0,0,0,0,1,0, 14'h0, 3'd5);
    check("R6 vector 5", 14'h0028);
    pulse(0,0,0,0,0,1, 14'h0, 3'd0);
    check("R6 return +1", 14'h0051);
    pulse(0,0,0,0,1,0, 14'h3FFF, 3'd0);
    check("R6 vector 0", 14'h0000);
    pulse(0,0,0,0,0,1, 14'h0, 3'd0);
    check("R6 second return", 14'h0052);
  endtask

  task automatic t_hold();
    do_reset();
    pulse(0,0,1,0,0,0, 14'h0050, 3'd0);
    pulse(1,1,0,0,0,0, 14'h0, 3'd0);
    check("R7 held advance", 14'h0050);
    pulse(0,1,0,0,1,0, 14'h0, 3'd7);
    check("R7 held vector", 14'h0038);
    pulse(0,0,0,0,0,1, 14'h0, 3'd0);
    check("R7 return no increment", 14'h0050);
    pulse(0,1,0,1,0,0, 14'h0200, 3'd0);
    pulse(0,0,0,0,0,1, 14'h0, 3'd0);
    check("R7 held call return", 14'h0050);
    pulse(1,0,0,0,0,0, 14'h0, 3'd0);
    check("R7 release advance", 14'h0051);
  endtask

  task automatic t_priority();
    do_reset();
    pulse(0,0,1,0,0,0, 14'h0151, 3'd0);
    pulse(1,0,1,1,1,1, 14'h0300, 3'd4);
    check("R9 call wins", 14'h0300);
    pulse(0,0,0,0,0,1, 14'h0, 3'd0);
    check("R9 call return", 14'h0154);
    pulse(1,0,1,0,1,1, 14'h03FF, 3'd2);
    check("R9 vector over jump", 14'h0010);
    pulse(0,0,0,0,0,1, 14'h0, 3'd0);
    check("R9 vector return", 14'h0155);
    pulse(1,0,1,0,0,1, 14'h0222, 3'd0);
    check("R9 jump over return", 14'h0222);
    pulse(1,0,0,0,0,1, 14'h0, 3'd0);
    check("R9 return over advance", 14'h0000);
  endtask

  task automatic t_wrap();
    do_reset();
    pulse(0,0,1,0,0,0, 14'h0010, 3'd0);
    for (int k = 1; k <= 8; k++) begin
      pulse(0,0,0,1,0,0, 14'(k << 8), 3'd0);
      check("R8 call chain", 14'(k << 8));
    end
    for (int j = 1; j <= 7; j++) begin
      pulse(0,0,0,0,0,1, 14'h0, 3'd0);
      check("R8 unwind", 14'(((8 - j) << 8) + 3));
    end
    pulse(0,0,0,0,0,1, 14'h0, 3'd0);
    check("R8 oldest overwritten", 14'h0800);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_step_jump();
    t_call_ret();
    t_vector();
    t_hold();
    t_priority();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule